// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block looks at every interrupt line that one CPU can receive and picks the one that should be serviced next. Each line has an enable bit, a pending bit and an 8-bit priority, where a smaller number means more urgent. A balanced comparison tree reduces all lines to one winner. The winner is then checked against two thresholds. The priority mask decides whether the winner is reported as the pending ID. The running priority, which is the priority of the interrupt the CPU is already handling, decides whether the request line is raised.

A distributor-wide enable and a per-CPU interface enable act as master gates. When either one is low, the block reports the spurious ID 1023 and keeps the request line low. The priority mask and the running priority live inside the block and are loaded through single-cycle write strobes. The per-line enable, pending and priority vectors arrive from storage outside the block. Both outputs are registered.

Top module: `irq_prio_select`

## Requirements
- R1: Only lines whose enable and pending bits are both 1 compete. Among those, the line with the numerically smallest priority wins. A priority is taken from byte k of `irq_prio` (bits 8k+7..8k) for line k.
- R2: When several competing lines share the smallest priority, the lowest line number wins.
- R3: With no competing line, `pend_id` is 1023 and `irq_req` is 0.
- R4: The winner is reported on `pend_id` only if its priority is less than or equal to the priority mask. Otherwise `pend_id` is 1023 and `irq_req` is 0.
- R5: `irq_req` is 1 only when the winner passes the mask and its priority is strictly less than the running priority. An equal running priority keeps the request low while the ID is still reported.
- R6: If `dist_en` or `cpu_en` is 0, `pend_id` is 1023 and `irq_req` is 0, whatever lines are pending.
- R7: Reset sets the outputs to 1023 and 0, the priority mask to 0xF0 and the running priority to 0x100 (idle, less urgent than any 8-bit priority). A running-priority write above 0x100 is stored as 0x100.
- R8: Outputs follow a change of `dist_en`, `cpu_en`, `irq_en`, `irq_pend` or `irq_prio` at the next rising clock edge. They follow a mask or running-priority write at the second rising edge after the strobe is sampled.
- R9: When NUM_IRQ is not a power of two, the padding positions of the tree are never selected, and `pend_id` is always 1023 or below NUM_IRQ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Distributor-wide enable |
| cpu_en | input | 1 | Enable of this CPU's interface |
| irq_en | input | NUM_IRQ | Per-line enable for this CPU |
| irq_pend | input | NUM_IRQ | Per-line pending bit for this CPU |
| irq_prio | input | 8*NUM_IRQ | Per-line priority, line k in byte k |
| mask_we | input | 1 | Load strobe for the priority mask |
| mask_wdata | input | 8 | New priority mask value |
| run_we | input | 1 | Load strobe for the running priority |
| run_wdata | input | 9 | New running priority (0x100 = idle) |
| pend_id | output | 10 | Reported pending line, 1023 = spurious |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block twice. The first instance uses the default NUM_IRQ of 64, which gives a full six-level tree. It lets the bench place winners at line 0, at line 63 and on ties that span both halves of the tree. The second instance uses NUM_IRQ of 5, which leaves three dead leaves in an eight-leaf tree. Pending bits driven above line 4 are visible to the wide instance but must never surface from the narrow one.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int PRIO_W = 8;
  localparam int ID_W   = 10;
  localparam logic [ID_W-1:0]   SPUR_ID   = {ID_W{1'b1}};
  localparam logic [PRIO_W:0]   PRIO_IDLE = {1'b1, {PRIO_W{1'b0}}};
  localparam logic [PRIO_W-1:0] MASK_RST  = 8'hF0;
endpackage

// File: rtl/irq_sel_tree.sv
module irq_sel_tree
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        en,
  input  logic [NUM_IRQ-1:0]        pend,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio,
  output logic [PRIO_W:0]           best_pr,
  output logic [ID_W-1:0]           best_id
);
  localparam int LVLS = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 0;
  localparam int PAD  = 1 << LVLS;

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int W = PAD >> l;
    logic [PRIO_W:0] pr [W];
    logic [ID_W-1:0] id [W];
    if (l == 0) begin : g_leaf
      for (genvar k = 0; k < W; k++) begin : g_k
        if (k < NUM_IRQ) begin : g_real
          assign pr[k] = (en[k] && pend[k]) ? {1'b0, prio[k*PRIO_W +: PRIO_W]} : PRIO_IDLE;
        end else begin : g_dead
          assign pr[k] = PRIO_IDLE;
        end
        assign id[k] = ID_W'(k);
      end
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_k
        // right half (higher IDs) wins only when strictly more urgent
        logic take_r;
        assign take_r = g_lvl[l-1].pr[2*k+1] < g_lvl[l-1].pr[2*k];
        assign pr[k]  = take_r ? g_lvl[l-1].pr[2*k+1] : g_lvl[l-1].pr[2*k];
        assign id[k]  = take_r ? g_lvl[l-1].id[2*k+1] : g_lvl[l-1].id[2*k];
      end
    end
  end

  assign best_pr = g_lvl[LVLS].pr[0];
  assign best_id = g_lvl[LVLS].id[0];

  // leaf-side view of the chosen line, for the checks below
  logic winner_ok;
  logic beaten;
  always_comb begin
    winner_ok = 1'b0;
    beaten    = 1'b0;
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (best_id == ID_W'(k))
        winner_ok = en[k] && pend[k] && ({1'b0, prio[k*PRIO_W +: PRIO_W]} == best_pr);
      if (en[k] && pend[k] && ({1'b0, prio[k*PRIO_W +: PRIO_W]} < best_pr))
        beaten = 1'b1;
    end
  end

  AST_WINNER_IS_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (best_pr != PRIO_IDLE) |-> winner_ok);  // R1
  AST_NO_BETTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !beaten);  // R1
endmodule

// File: rtl/irq_sel_thresh.sv
module irq_sel_thresh
  import irq_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [PRIO_W-1:0] mask_wdata,
  input  logic              run_we,
  input  logic [PRIO_W:0]   run_wdata,
  output logic [PRIO_W-1:0] mask_q,
  output logic [PRIO_W:0]   run_q
);
  logic [PRIO_W-1:0] mask_d;
  logic [PRIO_W:0]   run_d;

  always_comb begin
    mask_d = mask_q;
    run_d  = run_q;
    if (mask_we) mask_d = mask_wdata;
    if (run_we)  run_d  = (run_wdata > PRIO_IDLE) ? PRIO_IDLE : run_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      run_q  <= PRIO_IDLE;
    end else begin
      mask_q <= mask_d;
      run_q  <= run_d;
    end
  end

  AST_RUN_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= PRIO_IDLE);  // R7
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mask_we) |-> $stable(mask_q));  // R7
endmodule

// File: rtl/irq_sel_out.sv
module irq_sel_out
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dist_en,
  input  logic              cpu_en,
  input  logic [PRIO_W:0]   best_pr,
  input  logic [ID_W-1:0]   best_id,
  input  logic [PRIO_W-1:0] mask_q,
  input  logic [PRIO_W:0]   run_q,
  output logic [ID_W-1:0]   pend_id,
  output logic              irq_req
);
  logic            pass;
  logic [ID_W-1:0] id_d;
  logic            req_d;

  always_comb begin
    pass  = dist_en && cpu_en && (best_pr <= {1'b0, mask_q});
    id_d  = pass ? best_id : SPUR_ID;
    req_d = pass && (best_pr < run_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_id <= SPUR_ID;
      irq_req <= 1'b0;
    end else begin
      pend_id <= id_d;
      irq_req <= req_d;
    end
  end

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(dist_en) && $past(cpu_en)) |-> (pend_id == SPUR_ID && !irq_req));  // R6
  AST_REQ_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend_id != SPUR_ID));  // R5
  AST_REQ_BELOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($past(best_pr) < $past(run_q)));  // R5
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_id != SPUR_ID) |-> ($past(best_pr) <= {1'b0, $past(mask_q)}));  // R4
  AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_id == SPUR_ID) || (pend_id < ID_W'(NUM_IRQ)));  // R9
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dist_en,
  input  logic                      cpu_en,
  input  logic [NUM_IRQ-1:0]        irq_en,
  input  logic [NUM_IRQ-1:0]        irq_pend,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic                      mask_we,
  input  logic [PRIO_W-1:0]         mask_wdata,
  input  logic                      run_we,
  input  logic [PRIO_W:0]           run_wdata,
  output logic [ID_W-1:0]           pend_id,
  output logic                      irq_req
);
  logic [PRIO_W:0]   best_pr;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] mask_q;
  logic [PRIO_W:0]   run_q;

  irq_sel_tree #(.NUM_IRQ(NUM_IRQ)) u_tree (
    .clk(clk), .rst_n(rst_n), .en(irq_en), .pend(irq_pend), .prio(irq_prio),
    .best_pr(best_pr), .best_id(best_id)
  );

  irq_sel_thresh u_thresh (
    .clk(clk), .rst_n(rst_n),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .run_we(run_we), .run_wdata(run_wdata),
    .mask_q(mask_q), .run_q(run_q)
  );

  irq_sel_out #(.NUM_IRQ(NUM_IRQ)) u_out (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
    .best_pr(best_pr), .best_id(best_id), .mask_q(mask_q), .run_q(run_q),
    .pend_id(pend_id), .irq_req(irq_req)
  );
endmodule

// File: tb/tb_irq_prio_select.sv
module tb_irq_prio_select;
  localparam int CLK_P = 10;
  localparam int N  = 64;
  localparam int NO = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic dist_en, cpu_en;
  logic [N-1:0]   en, pend;
  logic [N*8-1:0] prio;
  logic mask_we, run_we;
  logic [7:0] mask_wdata;
  logic [8:0] run_wdata;
  logic [9:0] pend_id, odd_id;
  logic irq_req, odd_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_prio_select #(.NUM_IRQ(N)) dut (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
    .irq_en(en), .irq_pend(pend), .irq_prio(prio),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .run_we(run_we), .run_wdata(run_wdata),
    .pend_id(pend_id), .irq_req(irq_req)
  );

  irq_prio_select #(.NUM_IRQ(NO)) dut_odd (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
    .irq_en(en[NO-1:0]), .irq_pend(pend[NO-1:0]), .irq_prio(prio[NO*8-1:0]),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .run_we(run_we), .run_wdata(run_wdata),
    .pend_id(odd_id), .irq_req(odd_req)
  );

  typedef struct packed {
    logic [63:0] e;
    logic [63:0] p;
    logic [1:0]  mode;
    logic [7:0]  mask;
    logic [8:0]  run;
    logic [9:0]  eid;
    logic        ereq;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   2'd0, 8'hF0, 9'h100, 10'd1023, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h220,                 2'd0, 8'hF0, 9'h100, 10'd5,    1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0100_0000_0008, 2'd1, 8'hF0, 9'h100, 10'd40,   1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0008, 2'd1, 8'hF0, 9'h100, 10'd63,   1'b1},
    '{64'h8,                   64'h0000_0100_0000_0008, 2'd1, 8'hF0, 9'h100, 10'd1023, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h10_0400,             2'd2, 8'hF0, 9'h028, 10'd10,   1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h10_0400,             2'd2, 8'hF0, 9'h029, 10'd10,   1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 8'h00, 9'h100, 10'd0,    1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h2,                   2'd2, 8'h03, 9'h100, 10'd1023, 1'b0}
  };

  function automatic string tbl_tag(input int i);
    case (i)
      0: return "R3";
      1: return "R2";
      2, 3: return "R1";
      4, 8: return "R4";
      5, 6: return "R5";
      default: return "R1";
    endcase
  endfunction

  // mode 0: all 0x80; mode 1: 0xFF-k; mode 2: 4*k
  function automatic logic [N*8-1:0] fill_prio(input logic [1:0] mode);
    logic [N*8-1:0] v;
    for (int k = 0; k < N; k++) begin
      case (mode)
        2'd0:    v[8*k +: 8] = 8'h80;
        2'd1:    v[8*k +: 8] = 8'hFF - 8'(k);
        default: v[8*k +: 8] = 8'(4*k);
      endcase
    end
    return v;
  endfunction

  // linear reference scan: returns {req, id}
  function automatic logic [10:0] ref_sel(input logic [N-1:0] e, input logic [N-1:0] p,
                                          input logic [N*8-1:0] pr, input int n,
                                          input logic [7:0] m, input logic [8:0] r,
                                          input logic d, input logic c);
    logic [8:0] best = 9'h100;
    logic [9:0] bid  = 10'd1023;
    logic ok;
    for (int k = 0; k < n; k++)
      if (e[k] && p[k] && ({1'b0, pr[8*k +: 8]} < best)) begin
        best = {1'b0, pr[8*k +: 8]};
        bid  = 10'(k);
      end
    ok = d && c && (best <= {1'b0, m});
    return {ok && (best < r), ok ? bid : 10'd1023};
  endfunction

  task automatic check(input string tag, input logic [9:0] gid, input logic [9:0] eid,
                       input logic greq, input logic ereq);
    n_tests++;
    if (gid !== eid || greq !== ereq) begin
      n_fail++;
      $display("FAIL %s: id=%0d req=%0b expected id=%0d req=%0b", tag, gid, greq, eid, ereq);
    end
  endtask

  // drive all inputs with both strobes, wait until two rising edges have passed
  task automatic drive_all(input logic [N-1:0] e, input logic [N-1:0] p, input logic [N*8-1:0] pr,
                           input logic [7:0] m, input logic [8:0] r, input logic d, input logic c);
    @(negedge clk);
    en = e; pend = p; prio = pr; dist_en = d; cpu_en = c;
    mask_we = 1'b1; mask_wdata = m; run_we = 1'b1; run_wdata = r;
    @(negedge clk);
    mask_we = 1'b0; run_we = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: id=%0d req=%0b expected run to finish", pend_id, irq_req);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [10:0] r;
    rst_n = 1'b0; dist_en = 1'b1; cpu_en = 1'b1;
    en = '1; pend = '0; prio = '0;
    mask_we = 1'b0; run_we = 1'b0; mask_wdata = '0; run_wdata = '0;
    repeat (3) @(negedge clk);
    check("R7 reset outputs", pend_id, 10'd1023, irq_req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 after release", pend_id, 10'd1023, irq_req, 1'b0);

    // R7: defaults mask 0xF0 (inclusive) and running 0x100 (idle)
    prio = fill_prio(2'd0);
    prio[8*7 +: 8] = 8'hF0;
    pend = 64'h80;
    @(negedge clk);
    check("R7 default mask accepts F0, idle run", pend_id, 10'd7, irq_req, 1'b1);
    prio[8*7 +: 8] = 8'hF1;
    @(negedge clk);
    check("R7 default mask rejects F1", pend_id, 10'd1023, irq_req, 1'b0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      drive_all(TBL[i].e, TBL[i].p, fill_prio(TBL[i].mode), TBL[i].mask, TBL[i].run, 1'b1, 1'b1);
      check(tbl_tag(i), pend_id, TBL[i].eid, irq_req, TBL[i].ereq);
    end

    // R6: master gates
    drive_all('1, 64'h1000, fill_prio(2'd0), 8'hFF, 9'h100, 1'b0, 1'b1);
    check("R6 dist_en low", pend_id, 10'd1023, irq_req, 1'b0);
    drive_all('1, 64'h1000, fill_prio(2'd0), 8'hFF, 9'h100, 1'b1, 1'b0);
    check("R6 cpu_en low", pend_id, 10'd1023, irq_req, 1'b0);

    // R8: one-edge latency for vectors
    drive_all('1, 64'h80, {N{8'h10}}, 8'hFF, 9'h100, 1'b1, 1'b1);
    check("R8 base", pend_id, 10'd7, irq_req, 1'b1);
    pend = 64'h1000;
    #1;
    check("R8 before edge", pend_id, 10'd7, irq_req, 1'b1);
    @(negedge clk);
    check("R8 one edge after pending change", pend_id, 10'd12, irq_req, 1'b1);
    // R8: two-edge latency for mask write
    mask_we = 1'b1; mask_wdata = 8'h00;
    @(negedge clk);
    mask_we = 1'b0;
    check("R8 one edge after mask write", pend_id, 10'd12, irq_req, 1'b1);
    @(negedge clk);
    check("R8 two edges after mask write", pend_id, 10'd1023, irq_req, 1'b0);

    // R7: running write above 0x100 saturates to idle; R5 strict compare
    drive_all('1, 64'h1000, {N{8'h10}}, 8'hFF, 9'h1FF, 1'b1, 1'b1);
    check("R7 run write saturates", pend_id, 10'd12, irq_req, 1'b1);
    drive_all('1, 64'h1000, {N{8'h10}}, 8'hFF, 9'h010, 1'b1, 1'b1);
    check("R5 equal running blocks request", pend_id, 10'd12, irq_req, 1'b0);

    // R9: padded tree
    drive_all('1, 64'h10, {N{8'h40}}, 8'hFF, 9'h100, 1'b1, 1'b1);
    check("R9 odd last real line", odd_id, 10'd4, odd_req, 1'b1);
    drive_all('1, 64'hE0, {N{8'h40}}, 8'hFF, 9'h100, 1'b1, 1'b1);
    check("R9 odd ignores lines above range", odd_id, 10'd1023, odd_req, 1'b0);
    check("R9 wide sees line 5", pend_id, 10'd5, irq_req, 1'b1);
    drive_all('1, 64'h14, {N{8'h40}}, 8'hFF, 9'h100, 1'b1, 1'b1);
    check("R2 odd tie lowest wins", odd_id, 10'd2, odd_req, 1'b1);

    // random sweep against the linear scan (R1 R2 R4 R5 R6 R9)
    for (int it = 0; it < 80; it++) begin
      logic [N-1:0] e, p;
      logic [N*8-1:0] pr;
      logic [7:0] m;
      logic [8:0] rr;
      logic d, c;
      e = {$urandom, $urandom};
      p = {$urandom, $urandom};
      if (it % 3 == 0) p = p & {$urandom, $urandom} & {$urandom, $urandom};
      for (int k = 0; k < N; k++) pr[8*k +: 8] = (it % 2) ? 8'($urandom % 8) : 8'($urandom);
      m  = (it % 4 == 0) ? 8'($urandom) : 8'hFF;
      rr = 9'($urandom % 258);
      d  = ($urandom % 8) != 0;
      c  = ($urandom % 8) != 0;
      drive_all(e, p, pr, m, rr, d, c);
      r = ref_sel(e, p, pr, N, m, (rr > 9'h100) ? 9'h100 : rr, d, c);
      check("R1 random wide", pend_id, r[9:0], irq_req, r[10]);
      r = ref_sel(e, p, pr, NO, m, (rr > 9'h100) ? 9'h100 : rr, d, c);
      check("R9 random odd", odd_id, r[9:0], odd_req, r[10]);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule